// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides, cycle by cycle, whether a downstream timer/counter may advance. It drives one strobe, `ce_o`, in the system clock domain. A 3-bit source code picks where the strobe comes from:

- nothing, so the timer is frozen;
- every system clock;
- one of four power-of-two divisions taken from a shared free-running prescaler;
- edges seen on an external input pin, with the edge polarity chosen by the code.

The timer register, waveform logic and any software-visible registers belong to the surrounding design.

The prescaler is a free-running binary counter, 10 bits wide by default, that is shared by all divided codes. Each division is a tap that fires for one cycle whenever the tap's low-order counter bits are all zero. Changing the source code does not disturb the counter, so the phase of every division runs on from wherever it was. A synchronous clear input zeroes the counter so that a divided source can be started at a known phase.

The external pin is read as a level, whatever is driving it, including this chip's own output driver. It passes through a two-stage synchronizer and then through an edge detector. The strobe is registered, so a pin edge shows up on `ce_o` two to three system clocks after it happens.

Top module: `tcs_clk_select`

## Requirements
- R1: While `rst_ni` is low, `ce_o` is low. The prescaler counter and the pin history are cleared. With code 3'b010 selected, the first clock edge after release produces a `ce_o` pulse.
- R2: Code 3'b000 keeps `ce_o` low on every cycle.
- R3: Code 3'b001 holds `ce_o` high on every cycle.
- R4: Code 3'b010 gives exactly one single-cycle pulse in every 8 cycles. The pulse is driven on the clock edge that follows a cycle in which the low 3 prescaler bits are zero.
- R5: Code 3'b011 gives one pulse every 64 cycles, keyed to the low 6 counter bits.
- R6: Code 3'b100 gives one pulse every 256 cycles, keyed to the low 8 counter bits.
- R7: Code 3'b101 gives one pulse every 1024 cycles, keyed to all 10 counter bits.
- R8: Code 3'b110 gives one single-cycle pulse for each high-to-low transition of `ext_pin_i`. If the pin changes just before clock edge k, `ce_o` is high after edge k+2.
- R9: Code 3'b111 gives one single-cycle pulse for each low-to-high transition of `ext_pin_i`. The latency is the same as for R8. A pin that stays high does not repeat the pulse.
- R10: When `pre_clr_i` is high at edge k, the counter is zero after edge k. Every divided tap then fires after edge k+1.
- R11: Changing `sel_i` never resets or shifts the prescaler. A division selected later keeps its phase from the free-running counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronous to `clk_i` |
| sel_i | input | 3 | Count source code (see R2 to R9) |
| pre_clr_i | input | 1 | Synchronous clear of the shared prescaler counter |
| ext_pin_i | input | 1 | Raw external pin level, asynchronous to `clk_i` |
| ce_o | output | 1 | Registered count-enable strobe |

## Verification
The bench builds the block with its default parameters: taps at 3, 6, 8 and 10 counter bits and a two-stage synchronizer. With these values, the largest division of 1024 cycles fits inside a short run two full periods over, so the wrap of the whole counter is seen. The same values keep the pin latency at a fixed two edges after sampling, which lets the latency of R8 be checked cycle-exactly. A behavioural model predicts `ce_o` on every clock. It is driven through clears, mid-phase source changes, single-cycle pin pulses and a mid-run reset.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  // Count source codes; the numeric values are the select encoding.
  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_SYS      = 3'd1,
    SRC_DIV_A    = 3'd2,
    SRC_DIV_B    = 3'd3,
    SRC_DIV_C    = 3'd4,
    SRC_DIV_D    = 3'd5,
    SRC_PIN_FALL = 3'd6,
    SRC_PIN_RISE = 3'd7
  } src_sel_e;

  localparam int unsigned NUM_TAPS = 4;

  // Low-order bit count per tap; tap i divides by 2**TAP_LOG[i].
  typedef int unsigned tap_log_t [NUM_TAPS];
  localparam tap_log_t TAP_LOG_DEF = '{3, 6, 8, 10};

  localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter tcs_pkg::tap_log_t TAP_LOG = tcs_pkg::TAP_LOG_DEF,
  parameter int unsigned       CNT_W   = TAP_LOG[tcs_pkg::NUM_TAPS-1]
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  output logic [CNT_W-1:0]             cnt_o,
  output logic [tcs_pkg::NUM_TAPS-1:0] tap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Next state: free-running increment, synchronous clear wins.
  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // One tap per division: active while its low-order bits are all zero.
  for (genvar g = 0; g < tcs_pkg::NUM_TAPS; g++) begin : g_tap
    assign tap_o[g] = (cnt_q[TAP_LOG[g]-1:0] == '0);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge #(
  parameter int unsigned SYNC_STAGES = tcs_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  // Stages 0..SYNC_STAGES-1 synchronize; stage SYNC_STAGES keeps the prior level.
  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;
  logic [PIPE_W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[PIPE_W-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rise_o =  pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign fall_o = ~pipe_q[SYNC_STAGES-1] &  pipe_q[SYNC_STAGES];

endmodule

// File: rtl/tcs_clk_select.sv
module tcs_clk_select #(
  parameter tcs_pkg::tap_log_t TAP_LOG     = tcs_pkg::TAP_LOG_DEF,
  parameter int unsigned       SYNC_STAGES = tcs_pkg::SYNC_STAGES_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       pre_clr_i,
  input  logic       ext_pin_i,
  output logic       ce_o
);

  import tcs_pkg::*;

  localparam int unsigned CNT_W = TAP_LOG[NUM_TAPS-1];

  logic [CNT_W-1:0]    pre_cnt;
  logic [NUM_TAPS-1:0] taps;
  logic                pin_rise;
  logic                pin_fall;
  logic                ce_d;
  logic                ce_q;

  tcs_prescaler #(
    .TAP_LOG (TAP_LOG),
    .CNT_W   (CNT_W)
  ) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_clr_i),
    .cnt_o  (pre_cnt),
    .tap_o  (taps)
  );

  tcs_pin_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  // Source multiplexer.
  always_comb begin
    case (src_sel_e'(sel_i))
      SRC_OFF:      ce_d = 1'b0;
      SRC_SYS:      ce_d = 1'b1;
      SRC_DIV_A:    ce_d = taps[0];
      SRC_DIV_B:    ce_d = taps[1];
      SRC_DIV_C:    ce_d = taps[2];
      SRC_DIV_D:    ce_d = taps[3];
      SRC_PIN_FALL: ce_d = pin_fall;
      SRC_PIN_RISE: ce_d = pin_rise;
      default:      ce_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b0;
    end else begin
      ce_q <= ce_d;
    end
  end

  assign ce_o = ce_q;

endmodule

// File: rtl/tcs_clk_select_chk.sv
module tcs_clk_select_chk (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           sel_i,
  input logic                 pre_clr_i,
  input logic                 ce_o,
  input logic [CNT_W_C-1:0]   pre_cnt_i,
  input logic                 rise_i
);

  localparam int unsigned CNT_W_C = tcs_pkg::TAP_LOG_DEF[tcs_pkg::NUM_TAPS-1];
  localparam int unsigned TAP0    = tcs_pkg::TAP_LOG_DEF[0];

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!ce_o) else $error("ce_o high in reset"); // R1
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |=> !ce_o); // R2

  AST_SYS_EVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd1) |=> ce_o); // R3

  AST_DIV_A_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd2 && pre_cnt_i[TAP0-1:0] != '0) |=> !ce_o); // R4

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !rise_i); // R9

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_clr_i |=> (pre_cnt_i == '0)); // R10

  AST_FREE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_clr_i |=> (pre_cnt_i == $past(pre_cnt_i) + CNT_W_C'(1))); // R11

endmodule

bind tcs_clk_select tcs_clk_select_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .pre_clr_i (pre_clr_i),
  .ce_o      (ce_o),
  .pre_cnt_i (pre_cnt),
  .rise_i    (pin_rise)
);

// File: tb/tcs_clk_select_tb_top.sv
module tcs_clk_select_tb_top;

  logic       clk     = 1'b0;
  logic       rst_n   = 1'b0;
  logic [2:0] sel     = 3'd0;
  logic       pre_clr = 1'b0;
  logic       pin     = 1'b0;
  logic       ce;

  always #10 clk = ~clk;

  tcs_clk_select dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sel_i     (sel),
    .pre_clr_i (pre_clr),
    .ext_pin_i (pin),
    .ce_o      (ce)
  );

  int    n_chk   = 0;
  int    n_bad   = 0;
  int    cyc     = 0;
  int    ce_seen = 0;
  bit    cmp_on  = 1'b0;
  string cur_tag = "R1";

  // Behavioural reference state.
  int m_pc   = 0;
  bit hist[$];
  bit exp_ce = 1'b0;

  initial hist = '{1'b0, 1'b0, 1'b0};

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ce_o actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // Model: hist[0] newest sample, hist[1] synchronized level, hist[2] previous level.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc   = 0;
      hist   = '{1'b0, 1'b0, 1'b0};
      exp_ce = 1'b0;
    end else begin
      case (sel)
        3'd0: exp_ce = 1'b0;
        3'd1: exp_ce = 1'b1;
        3'd2: exp_ce = (m_pc % 8 == 0);
        3'd3: exp_ce = (m_pc % 64 == 0);
        3'd4: exp_ce = (m_pc % 256 == 0);
        3'd5: exp_ce = (m_pc % 1024 == 0);
        3'd6: exp_ce = !hist[1] && hist[2];
        default: exp_ce = hist[1] && !hist[2];
      endcase
      m_pc = pre_clr ? 0 : (m_pc + 1) % 1024;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (ce === 1'b1) ce_seen++;
    if (cmp_on) check(ce, exp_ce, cur_tag);
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic count_ce(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ce === 1'b1) c++;
    end
  endtask

  task automatic pin_pulse(input int hi, input int lo);
    pin = 1'b1;
    repeat (hi) @(negedge clk);
    pin = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic count_check(input int got, input int want, input string tag);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: pulse count actual=%0d expected=%0d", tag, got, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int c;
    int base;
    repeat (3) @(negedge clk);
    check(ce, 1'b0, "R1");                 // quiet in reset
    sel    = 3'd2;
    rst_n  = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    check(ce, 1'b1, "R1");                 // counter starts at zero
    cur_tag = "R4";
    count_ce(64, c);   count_check(c, 8, "R4");
    cur_tag = "R2"; sel = 3'd0;
    count_ce(30, c);   count_check(c, 0, "R2");
    cur_tag = "R3"; sel = 3'd1;
    count_ce(20, c);   count_check(c, 20, "R3");
    cur_tag = "R5"; sel = 3'd3;
    count_ce(256, c);  count_check(c, 4, "R5");
    cur_tag = "R6"; sel = 3'd4;
    count_ce(512, c);  count_check(c, 2, "R6");
    cur_tag = "R7"; sel = 3'd5;
    count_ce(2048, c); count_check(c, 2, "R7");

    // R10: one-cycle clear re-phases the /64 tap.
    cur_tag = "R10"; sel = 3'd3;
    repeat (13) @(negedge clk);
    pre_clr = 1'b1;
    @(negedge clk);
    pre_clr = 1'b0;
    @(negedge clk);
    check(ce, 1'b1, "R10");
    count_ce(63, c);   count_check(c, 0, "R10");
    @(negedge clk);
    check(ce, 1'b1, "R10");
    // R10: held clear keeps the /8 tap firing.
    sel = 3'd2;
    pre_clr = 1'b1;
    repeat (5) @(negedge clk);
    pre_clr = 1'b0;
    repeat (20) @(negedge clk);

    // R11: switching codes keeps the counter phase.
    cur_tag = "R11";
    pre_clr = 1'b1;
    @(negedge clk);
    pre_clr = 1'b0;
    repeat (5) @(negedge clk);
    sel = 3'd3;
    count_ce(59, c);   count_check(c, 0, "R11");
    @(negedge clk);
    check(ce, 1'b1, "R11");
    sel = 3'd4;
    repeat (100) @(negedge clk);
    sel = 3'd2;
    repeat (30) @(negedge clk);

    // R8: falling pin edges, exact latency then pulse count.
    cur_tag = "R8"; sel = 3'd6;
    pin = 1'b1;
    repeat (6) @(negedge clk);
    pin = 1'b0;
    @(negedge clk); check(ce, 1'b0, "R8");
    @(negedge clk); check(ce, 1'b0, "R8");
    @(negedge clk); check(ce, 1'b1, "R8");
    @(negedge clk); check(ce, 1'b0, "R8");
    repeat (3) @(negedge clk);
    base = ce_seen;
    pin_pulse(1, 1); pin_pulse(2, 1); pin_pulse(1, 3); pin_pulse(7, 2);
    repeat (5) @(negedge clk);
    count_check(ce_seen - base, 4, "R8");

    // R9: rising pin edges, including a pin held high.
    cur_tag = "R9"; sel = 3'd7;
    base = ce_seen;
    pin_pulse(1, 1); pin_pulse(2, 1); pin_pulse(1, 3); pin_pulse(40, 2);
    repeat (5) @(negedge clk);
    count_check(ce_seen - base, 4, "R9");
    // R2: pin activity has no effect when stopped.
    cur_tag = "R2"; sel = 3'd0;
    base = ce_seen;
    pin_pulse(2, 2); pin_pulse(1, 4);
    count_check(ce_seen - base, 0, "R2");

    // R1: reset in mid-run.
    cur_tag = "R1"; sel = 3'd1;
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ce, 1'b0, "R1");
    sel   = 3'd2;
    rst_n = 1'b1;
    @(negedge clk);
    check(ce, 1'b1, "R1");
    repeat (40) @(negedge clk);
    finish_run();
  end

endmodule